// File: doc/BRIEF.md
# Transmit FIFO Frame Admission Controller

This block sits between a DMA engine that writes transmit frames into a FIFO and the MAC logic that drains that FIFO. It decides two things every cycle. The first is whether the DMA may keep loading data: a permit output. The second is whether the MAC side should be reading: a read-enable output that stays up for the length of one frame.

The FIFO holds at most two frames that are not yet retired. A frame is counted as resident from the cycle its last word is written until the MAC returns its completion status. In the default mode the DMA waits for that status before it loads another frame. In the early-fetch mode the DMA may load a second frame while the first one is still waiting for its status.

The MAC may start reading a frame before the frame is complete, as soon as the FIFO fill level rises above a programmable threshold. It always starts when a completely written frame has not yet been read. A store-and-forward mode turns off the threshold start.

Top module: `tx_frame_gate`

## Requirements
- R1: After reset, `fetch_ok` is 1 and `rd_go` is 0.
- R2: When `rd_go` is 0, `sf_mode` is 0 and `fill_level` is strictly greater than `thresh`, `rd_go` is 1 from the next cycle.
- R3: When `rd_go` is 0 and at least one fully written frame has not yet been read out, `rd_go` is 1 from the next cycle. This holds whatever the fill level, the threshold and `sf_mode` are.
- R4: Once `rd_go` is 1, it stays 1 until a cycle in which `rd_eof` is 1, and it is 0 in the cycle after that one.
- R5: No more than two written frames are resident. With two resident and no frame partly written, `fetch_ok` is 0.
- R6: With `osf_en` = 1 and exactly one resident frame, `fetch_ok` is 1.
- R7: With `osf_en` = 0, `fetch_ok` is 0 from the cycle after a frame's last word is written. It stays 0 while any frame is resident.
- R8: A write with `wr_valid` = 1 and `wr_last` = 1 adds one resident frame. A `stat_done` pulse removes one. A `stat_done` pulse with nothing resident has no effect, and `fetch_ok` follows the new count in the next cycle.
- R9: With `sf_mode` = 1, the fill level and threshold have no effect: `rd_go` stays 0 until a complete unread frame exists.
- R10: While a frame is partly written (a write with `wr_last` = 0 has been seen and its last word has not), `fetch_ok` stays 1 even if `osf_en` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | DMA writes one word into the FIFO this cycle |
| wr_last | input | 1 | The written word ends its frame |
| fill_level | input | LVL_W | Current FIFO occupancy in words |
| thresh | input | LVL_W | Early-read threshold in words |
| osf_en | input | 1 | Allow fetching a second frame before the first one's status |
| sf_mode | input | 1 | Store-and-forward: read only complete frames |
| rd_eof | input | 1 | MAC side popped the last word of the frame it is reading |
| stat_done | input | 1 | MAC returned completion status for the oldest frame |
| fetch_ok | output | 1 | DMA may load frame data |
| rd_go | output | 1 | MAC side should read the FIFO |

## Verification
Directed runs cover the two ways a read can start: a threshold crossing on a partial frame, and a complete frame present with the fill level at zero. The same threshold crossing is then repeated in store-and-forward mode, which shows whether the threshold path is really gated off. Frame sequences are run with early fetch on and off, which separates the one-frame and two-frame limits. A status pulse with nothing resident, and a mode change in the middle of a frame, exercise the ignore and hold cases. A long seeded random phase mixes writes, frame ends, status pulses and mode changes, and checks both outputs every cycle against a model kept in the bench.

// File: rtl/tx_frame_gate.sv
module tx_frame_gate #(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_last,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             osf_en,
  input  logic             sf_mode,
  input  logic             rd_eof,
  input  logic             stat_done,
  output logic             fetch_ok,
  output logic             rd_go
);

  localparam logic [1:0] CAP = 2'd2;

  logic [1:0] res_q;
  logic [1:0] unread_q;
  logic       loading_q;

  wire eof_in  = wr_valid & wr_last;
  wire done_in = stat_done & (res_q != 2'd0);
  wire eof_out = rd_go & rd_eof & (unread_q != 2'd0);
  wire res_inc = eof_in & ((res_q != CAP) | done_in);
  wire unr_inc = eof_in & ((unread_q != CAP) | eof_out);
  wire thr_hit = !sf_mode && (fill_level > thresh);

  assign fetch_ok = loading_q || (res_q == 2'd0) || (osf_en && res_q == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= 2'd0;
      unread_q  <= 2'd0;
      loading_q <= 1'b0;
      rd_go     <= 1'b0;
    end else begin
      res_q    <= res_q + {1'b0, res_inc} - {1'b0, done_in};
      unread_q <= unread_q + {1'b0, unr_inc} - {1'b0, eof_out};
      if (wr_valid) loading_q <= !wr_last;
      if (rd_go) rd_go <= !rd_eof;
      else       rd_go <= (unread_q != 2'd0) || thr_hit;
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && !rd_eof |=> rd_go);
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && rd_eof |=> !rd_go);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go && unread_q != 2'd0 |=> rd_go);
  p_sf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sf_mode && !rd_go && unread_q == 2'd0 && !eof_in |=> !rd_go);
  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eof_in && res_q == 2'd1 && !stat_done |=> !fetch_ok);
  p_osfoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_in && !done_in && !osf_en |=> !fetch_ok || osf_en);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done && res_q == 2'd1 && !wr_valid |=> fetch_ok);

endmodule

// File: tb/sim_tx_frame_gate.sv
module sim_tx_frame_gate;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_last = 0, osf_en = 0, sf_mode = 0, rd_eof = 0, stat_done = 0;
  logic [LW-1:0] fill_level = '0, thresh = '0;
  logic fetch_ok, rd_go;

  int n_chk = 0, n_bad = 0;
  int m_res = 0, m_unr = 0;
  bit m_load = 0, m_go = 0;

  always #5 clk = ~clk;

  tx_frame_gate #(.LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .fill_level(fill_level), .thresh(thresh), .osf_en(osf_en), .sf_mode(sf_mode),
    .rd_eof(rd_eof), .stat_done(stat_done), .fetch_ok(fetch_ok), .rd_go(rd_go));

  function automatic bit exp_fetch(bit ld, int res, bit osf);
    return ld || res == 0 || (osf && res == 1);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v, bit l, bit e, bit s, int f, int t);
    int nres, nunr;
    bit nload, ngo, ev_eof, ev_done;
    wr_valid = v; wr_last = l; rd_eof = e; stat_done = s;
    fill_level = LW'(f); thresh = LW'(t);
    ev_eof  = m_go && e && m_unr > 0;
    ev_done = s && m_res > 0;
    nres = m_res - (ev_done ? 1 : 0);
    if (v && l && nres < 2) nres++;
    nunr = m_unr - (ev_eof ? 1 : 0);
    if (v && l && nunr < 2) nunr++;
    nload = v ? !l : m_load;
    ngo = m_go ? !e : (m_unr > 0 || (!sf_mode && f > t));
    @(negedge clk);
    m_res = nres; m_unr = nunr; m_load = nload; m_go = ngo;
    chk({tag, " fetch_ok"}, fetch_ok, exp_fetch(m_load, m_res, osf_en));
    chk({tag, " rd_go"}, rd_go, m_go);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 fetch_ok", fetch_ok, 1'b1);
    chk("R1 rd_go", rd_go, 1'b0);

    // R9: threshold ignored in store-and-forward
    sf_mode = 1;
    step("R9", 0, 0, 0, 0, 50, 10);
    chk("R9 no early read", rd_go, 1'b0);
    // R2: threshold start, then R4 hold and drop
    sf_mode = 0;
    step("R2", 0, 0, 0, 0, 50, 10);
    chk("R2 early read", rd_go, 1'b1);
    step("R4", 0, 0, 0, 0, 0, 10);
    chk("R4 hold", rd_go, 1'b1);
    step("R4", 0, 0, 1, 0, 0, 10);
    chk("R4 drop", rd_go, 1'b0);

    // R7 and R3: one frame, early fetch off
    osf_en = 0;
    step("R7", 1, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 0, 0);
    chk("R7 blocked", fetch_ok, 1'b0);
    step("R3", 0, 0, 0, 0, 0, 0);
    chk("R3 full frame read", rd_go, 1'b1);
    step("R4", 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0);
    chk("R7 still blocked", fetch_ok, 1'b0);
    step("R8", 0, 0, 0, 1, 0, 0);
    chk("R8 released", fetch_ok, 1'b1);
    step("R8", 0, 0, 0, 1, 0, 0);
    chk("R8 spare done ignored", fetch_ok, 1'b1);
    osf_en = 1;
    idle("R8", 1);

    // R6, R5: two frames with early fetch
    step("R6", 1, 1, 0, 0, 0, 0);
    chk("R6 second allowed", fetch_ok, 1'b1);
    step("R5", 1, 1, 0, 0, 0, 0);
    chk("R5 cap", fetch_ok, 1'b0);
    idle("R5", 2);
    chk("R5 cap held", fetch_ok, 1'b0);
    step("R4", 0, 0, 1, 0, 0, 0);
    idle("R3", 1);
    step("R4", 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    chk("R8 one left", fetch_ok, 1'b1);
    step("R8", 0, 0, 0, 1, 0, 0);

    // R10: mode drops mid-frame
    step("R10", 1, 1, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0);
    osf_en = 0;
    step("R10", 0, 0, 0, 0, 0, 0);
    chk("R10 mid-frame permit", fetch_ok, 1'b1);
    step("R10", 1, 1, 0, 0, 0, 0);
    chk("R5 after mid-frame end", fetch_ok, 1'b0);
    for (int k = 0; k < 6 && (m_unr > 0 || m_go); k++) step("R4", 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 3 && m_res > 0; k++) step("R8", 0, 0, 0, 1, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v, l, e, s;
      if ($urandom % 50 == 0) osf_en = ~osf_en;
      if ($urandom % 60 == 0) sf_mode = ~sf_mode;
      v = exp_fetch(m_load, m_res, osf_en) && ($urandom % 2 == 0);
      l = v && ($urandom % 4 == 0);
      e = m_go && m_unr > 0 && ($urandom % 3 == 0);
      s = (m_res > m_unr) && ($urandom % 4 == 0);
      step("R2/R3 random", v, l, e, s, int'($urandom % 64), int'($urandom % 64));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule